// File: doc/BRIEF.md
# Dual Charge Pump Controller

This block is the digital front end of a PLL synthesizer. It compares a reference pulse train with the divided oscillator pulse train and turns the phase error between their rising edges into up/down commands for two charge pumps. The main pump always follows the phase detector. A second pump helps the loop lock faster. A two-bit mode code decides whether this pump drives or floats, and in one mode it drives only while the loop is out of lock. A lock flag comes from the width of the detector pulses, measured against a programmable limit.

Both pulse trains are sampled in the system clock domain, so phase error is resolved in whole system-clock cycles. An inhibit input puts the block in a backup state. Both pumps float, the detector is held clear and the lock flag drops. A pump that floats shows its output-enable bit low, and its up and down commands are held low.

Top module: `dcp_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every pump output (`main_up`, `main_dn`, `main_oe`, `sub_up`, `sub_dn`, `sub_oe`) and `locked` are 0 after that edge.
- R2: When the reference rising edge leads the divided rising edge by d cycles (0 < d < period), `main_up` is high for exactly d consecutive cycles per period and `main_dn` stays low.
- R3: When the divided rising edge leads the reference rising edge by d cycles, `main_dn` is high for exactly d cycles per period and `main_up` stays low.
- R4: When both rising edges reach the block in the same cycle, neither `main_up` nor `main_dn` pulses, and the two are never high together.
- R5: With mode bit 1 at 0 (codes 00 and 01), `sub_oe`, `sub_up` and `sub_dn` stay 0.
- R6: With mode code 11, `sub_oe` is 1 and `sub_up`/`sub_dn` equal `main_up`/`main_dn` in every cycle.
- R7: With mode code 10, the secondary pump behaves as in R6 while `locked` is 0, and floats as in R5 while `locked` is 1.
- R8: A new value on `mode` takes effect only at the next reference rising edge. Before that edge the secondary pump keeps the behaviour of the previous code.
- R9: While `inhibit` is 1, both output enables and all up/down commands are 0 and `locked` is cleared.
- R10: A comparison period is the interval between reference rising edges. Its detector pulse width in cycles counts as good when it does not exceed `lock_thresh`. `locked` rises after 4 consecutive good periods.
- R11: `locked` falls right after the first period whose width exceeds `lock_thresh`. After that, 4 new consecutive good periods are needed to set it again.
- R12: While `inhibit` is 0 and reset is released, `main_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference pulse train |
| div_in | input | 1 | Divided oscillator pulse train |
| mode | input | 2 | Secondary pump mode code |
| inhibit | input | 1 | Backup state: float both pumps, clear lock |
| lock_thresh | input | CNT_W | Largest pulse width, in cycles, that counts as good |
| main_up | output | 1 | Main pump up command |
| main_dn | output | 1 | Main pump down command |
| main_oe | output | 1 | Main pump drive enable (0 = floating) |
| sub_up | output | 1 | Secondary pump up command |
| sub_dn | output | 1 | Secondary pump down command |
| sub_oe | output | 1 | Secondary pump drive enable (0 = floating) |
| locked | output | 1 | Lock flag |

## Verification
The hardest case to reach from the ports is the one-period lag of the lock flag. A period's width is judged only at the following reference edge. So a drop, or the fourth good period, shows up on `locked` one period after the pulse that caused it. The bench first drives a period whose width is over the limit, so the qualifying count starts from a known state. It then drives pulses exactly at the limit and one cycle over it, and checks `locked` and the mode-10 secondary enable at the end of each period. A mode write is made mid-period, after the reference edge has passed, so that the deferred switch can be seen.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam logic [1:0] MODE_FLOAT_A  = 2'b00;
  localparam logic [1:0] MODE_FLOAT_B  = 2'b01;
  localparam logic [1:0] MODE_UNLOCKED = 2'b10;
  localparam logic [1:0] MODE_ALWAYS   = 2'b11;

  typedef struct packed {
    logic up;
    logic dn;
    logic oe;
  } pump_drive_t;

  function automatic pump_drive_t drive_of(input logic en, input logic up, input logic dn);
    pump_drive_t d;
    d.oe = en;
    d.up = en & up;
    d.dn = en & dn;
    return d;
  endfunction
endpackage

// File: rtl/dcp_edge_sync.sv
module dcp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // a rising edge is a single-cycle event, so pulse widths stay exact
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dcp_pfd.sv
module dcp_pfd (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic ref_rise,
  input  logic div_rise,
  output logic up,
  output logic dn
);
  logic up_q, dn_q;
  logic up_set, dn_set, both;

  assign up_set = up_q | ref_rise;
  assign dn_set = dn_q | div_rise;
  assign both   = up_set & dn_set;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (both) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_set;
      dn_q <= dn_set;
    end
  end

  assign up = up_q;
  assign dn = dn_q;

  assert_pfd_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(up_q && dn_q));
  assert_pfd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!up_q && !dn_q));
endmodule

// File: rtl/dcp_lock_det.sv
module dcp_lock_det #(
  parameter int CNT_W      = 8,
  parameter int LOCK_COUNT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ref_rise,
  input  logic             active,
  input  logic [CNT_W-1:0] thresh,
  output logic             locked
);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  logic [CNT_W-1:0]  width_q;
  logic [GOOD_W-1:0] good_q;
  logic              locked_q;
  logic [CNT_W:0]    w_eval;
  logic              bad;

  // width of the period closing now, including this cycle's activity
  assign w_eval = {1'b0, width_q} + {{CNT_W{1'b0}}, active};
  assign bad    = w_eval > {1'b0, thresh};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      width_q  <= '0;
      good_q   <= '0;
      locked_q <= 1'b0;
    end else if (ref_rise) begin
      width_q <= '0;
      if (bad) begin
        good_q   <= '0;
        locked_q <= 1'b0;
      end else if (good_q >= GOOD_LAST) begin
        good_q   <= GOOD_LAST;
        locked_q <= 1'b1;
      end else begin
        good_q <= good_q + 1'b1;
      end
    end else if (w_eval[CNT_W]) begin
      width_q <= '1;
    end else begin
      width_q <= w_eval[CNT_W-1:0];
    end
  end

  assign locked = locked_q;

  assert_lock_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && bad) |=> !locked_q);
  assert_lock_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !locked_q);
  assert_lock_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> $past(ref_rise));
endmodule

// File: rtl/dcp_pump_gate.sv
module dcp_pump_gate
  import dcp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inhibit,
  input  logic       ref_rise,
  input  logic [1:0] mode,
  input  logic       locked,
  input  logic       up,
  input  logic       dn,
  output logic       main_up,
  output logic       main_dn,
  output logic       main_oe,
  output logic       sub_up,
  output logic       sub_dn,
  output logic       sub_oe
);
  logic [1:0]  mode_act;
  logic [1:0]  en;
  pump_drive_t drv_d [2];
  pump_drive_t drv_q [2];

  always_ff @(posedge clk) begin
    if (rst) mode_act <= MODE_FLOAT_A;
    else if (ref_rise) mode_act <= mode;
  end

  assign en[0] = ~inhibit;
  assign en[1] = ~inhibit & mode_act[1] &
                 ((mode_act == MODE_ALWAYS) | ((mode_act == MODE_UNLOCKED) & ~locked));

  for (genvar g = 0; g < 2; g++) begin : g_pump
    assign drv_d[g] = drive_of(en[g], up, dn);
    always_ff @(posedge clk) begin
      if (rst) drv_q[g] <= '0;
      else     drv_q[g] <= drv_d[g];
    end
  end

  assign main_up = drv_q[0].up;
  assign main_dn = drv_q[0].dn;
  assign main_oe = drv_q[0].oe;
  assign sub_up  = drv_q[1].up;
  assign sub_dn  = drv_q[1].dn;
  assign sub_oe  = drv_q[1].oe;

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(ref_rise) |-> $stable(mode_act));
  assert_inhibit_float_R9: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (!main_oe && !sub_oe && !main_up && !main_dn && !sub_up && !sub_dn));
  assert_sub_float_R5: assert property (@(posedge clk) disable iff (rst)
    !sub_oe |-> (!sub_up && !sub_dn));
  assert_sub_follow_R6: assert property (@(posedge clk) disable iff (rst)
    sub_oe |-> (sub_up == main_up && sub_dn == main_dn));
  assert_main_drive_R12: assert property (@(posedge clk) disable iff (rst)
    !inhibit |=> main_oe);
endmodule

// File: rtl/dcp_ctrl.sv
module dcp_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int LOCK_COUNT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             div_in,
  input  logic [1:0]       mode,
  input  logic             inhibit,
  input  logic [CNT_W-1:0] lock_thresh,
  output logic             main_up,
  output logic             main_dn,
  output logic             main_oe,
  output logic             sub_up,
  output logic             sub_dn,
  output logic             sub_oe,
  output logic             locked
);
  logic [1:0] pin_in;
  logic [1:0] pin_rise;
  logic       pfd_up, pfd_dn;
  logic       lock_w;

  assign pin_in = {div_in, ref_in};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    dcp_edge_sync #(.STAGES(SYNC_STAGES)) edge_i (
      .clk  (clk),
      .rst  (rst),
      .din  (pin_in[g]),
      .rise (pin_rise[g])
    );
  end

  dcp_pfd pfd_i (
    .clk      (clk),
    .rst      (rst),
    .hold     (inhibit),
    .ref_rise (pin_rise[0]),
    .div_rise (pin_rise[1]),
    .up       (pfd_up),
    .dn       (pfd_dn)
  );

  dcp_lock_det #(.CNT_W(CNT_W), .LOCK_COUNT(LOCK_COUNT)) lock_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (inhibit),
    .ref_rise (pin_rise[0]),
    .active   (pfd_up | pfd_dn),
    .thresh   (lock_thresh),
    .locked   (lock_w)
  );

  dcp_pump_gate gate_i (
    .clk      (clk),
    .rst      (rst),
    .inhibit  (inhibit),
    .ref_rise (pin_rise[0]),
    .mode     (mode),
    .locked   (lock_w),
    .up       (pfd_up),
    .dn       (pfd_dn),
    .main_up  (main_up),
    .main_dn  (main_dn),
    .main_oe  (main_oe),
    .sub_up   (sub_up),
    .sub_dn   (sub_dn),
    .sub_oe   (sub_oe)
  );

  assign locked = lock_w;
endmodule

// File: tb/dcp_ctrl_tb_top.sv
module dcp_ctrl_tb_top;
  localparam int CNT_W = 8;
  localparam int PER   = 40;
  localparam int A0    = 10;
  localparam int HW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, div_in = 1'b0, inhibit = 1'b0;
  logic [1:0] mode = 2'b11;
  logic [CNT_W-1:0] lock_thresh = 8'd3;
  logic main_up, main_dn, main_oe, sub_up, sub_dn, sub_oe, locked;

  int checks = 0, fails = 0;
  int upc, dnc, supc, sdnc;
  logic e_lock, e_moe, e_soe;
  bit done = 0;

  always #2.5 clk = ~clk;

  dcp_ctrl #(.SYNC_STAGES(2), .CNT_W(CNT_W), .LOCK_COUNT(4)) dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .div_in(div_in), .mode(mode),
    .inhibit(inhibit), .lock_thresh(lock_thresh),
    .main_up(main_up), .main_dn(main_dn), .main_oe(main_oe),
    .sub_up(sub_up), .sub_dn(sub_dn), .sub_oe(sub_oe), .locked(locked));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one comparison period: ref rises at A0, div at A0+off; optional mid-period mode write
  task automatic run_period(input int off, input int chg_at, input logic [1:0] chg_mode);
    upc = 0; dnc = 0; supc = 0; sdnc = 0;
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      upc  += int'(main_up);
      dnc  += int'(main_dn);
      supc += int'(sub_up);
      sdnc += int'(sub_dn);
      if (c == PER - 1) begin
        e_lock = locked; e_moe = main_oe; e_soe = sub_oe;
      end
      if (c == chg_at) mode = chg_mode;
      ref_in = (c >= A0 && c < A0 + HW);
      div_in = (c >= A0 + off && c < A0 + off + HW);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({main_up, main_dn, main_oe, sub_up, sub_dn, sub_oe, locked} == 7'b0, "R1", 
          int'({main_up, main_dn, main_oe, sub_up, sub_dn, sub_oe, locked}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(main_oe == 1'b1, "R12", int'(main_oe), 1);

    // exhaustive sweep of phase offsets in mode 11
    for (int off = -8; off <= 8; off++) begin
      run_period(off, -1, 2'b11);
      run_period(off, -1, 2'b11);
      if (off > 0) begin
        check(upc == off && dnc == 0, "R2", upc * 100 + dnc, off * 100);
      end else if (off < 0) begin
        check(dnc == -off && upc == 0, "R3", dnc * 100 + upc, -off * 100);
      end else begin
        check(upc == 0 && dnc == 0, "R4", upc + dnc, 0);
      end
      check(supc == upc && sdnc == dnc && e_soe, "R6", supc * 100 + sdnc, upc * 100 + dnc);
      check(e_moe == 1'b1, "R12", int'(e_moe), 1);
    end

    // R5: both codes with upper bit clear float the secondary pump
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m);
      run_period(5, -1, 2'b00);
      run_period(5, -1, 2'b00);
      check(supc == 0 && sdnc == 0 && !e_soe, "R5", supc + int'(e_soe), 0);
      check(upc == 5, "R2", upc, 5);
    end

    // lock sequence in mode 10, threshold 3
    mode = 2'b10;
    lock_thresh = 8'd3;
    run_period(4, -1, 2'b10);                  // bad period clears the count
    for (int g = 1; g <= 5; g++) begin
      run_period(3, -1, 2'b10);                // width equal to threshold is good
      if (g == 4) begin
        check(e_lock == 1'b0, "R10", int'(e_lock), 0);
        check(e_soe == 1'b1, "R7", int'(e_soe), 1);
      end
      if (g == 5) begin
        check(e_lock == 1'b1, "R10", int'(e_lock), 1);
        check(e_soe == 1'b0, "R7", int'(e_soe), 0);
      end
    end
    run_period(3, -1, 2'b10);
    check(supc == 0 && upc == 3, "R7", supc, 0);
    run_period(4, -1, 2'b10);                  // one cycle over the threshold
    check(e_lock == 1'b1, "R11", int'(e_lock), 1);
    run_period(3, -1, 2'b10);
    check(e_lock == 1'b0, "R11", int'(e_lock), 0);
    check(e_soe == 1'b1 && supc == upc, "R7", int'(e_soe), 1);
    for (int g = 2; g <= 5; g++) begin
      run_period(3, -1, 2'b10);
      if (g == 4) check(e_lock == 1'b0, "R11", int'(e_lock), 0);
      if (g == 5) check(e_lock == 1'b1, "R11", int'(e_lock), 1);
    end

    // R8: mid-period mode writes wait for the next reference edge
    mode = 2'b11;
    run_period(3, -1, 2'b11);
    run_period(3, 25, 2'b00);
    check(e_soe == 1'b1, "R8", int'(e_soe), 1);
    run_period(3, -1, 2'b00);
    check(e_soe == 1'b0 && supc == 0, "R8", int'(e_soe), 0);
    run_period(3, 25, 2'b11);
    check(e_soe == 1'b0, "R8", int'(e_soe), 0);
    run_period(3, -1, 2'b11);
    check(e_soe == 1'b1 && supc == 3, "R8", supc, 3);

    // R9: inhibit floats everything and clears the lock
    check(locked == 1'b1, "R10", int'(locked), 1);
    inhibit = 1'b1;
    run_period(5, -1, 2'b11);
    check(!e_moe && !e_soe, "R9", int'({e_moe, e_soe}), 0);
    check(upc == 0 && dnc == 0 && supc == 0 && sdnc == 0, "R9", upc + dnc + supc + sdnc, 0);
    check(e_lock == 1'b0, "R9", int'(e_lock), 0);
    inhibit = 1'b0;
    run_period(5, -1, 2'b11);
    check(e_moe == 1'b1, "R12", int'(e_moe), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule